// File: doc/BRIEF.md
# Trap Entry Router

This block takes a single hart's pending exception or interrupt and works out which privilege level handles it. It then produces, in one registered step, every state change that entering the handler requires: the write strobe and values for the cause, return-address and trap-value registers of the chosen level, the new status bits, the next program counter and a pulse that drops any outstanding load reservation. A non-maskable interrupt bypasses all delegation, lands in machine mode and turns off the non-maskable enable so that the handler is not entered over and over.

The caller presents the current privilege, the status bits, the delegation masks and the three vector base registers every cycle, together with a one-cycle trap request. The block holds none of that architectural state itself. It only registers the update. The caller writes the update back when the strobes are high. While reset is asserted, the outputs carry the reset update instead: machine privilege, both machine interrupt enable and modify-privilege cleared, and a jump to a fixed reset address.

Top module: `trap_entry_ctrl`

## Requirements
- R1: A trap with the non-maskable flag set always targets machine mode, whatever the delegation masks hold. Its update drives nmiEnWe high and nmiEnOut low. On any other trap, nmiEnWe is low and nmiEnOut repeats nmiEnIn.
- R2: Privilege encodings are user 0, supervisor 1 and machine 3. A trap taken in machine mode is never delegated. From user or supervisor mode, a set machine-level delegation bit sends the trap to supervisor if hasSup is 1. If hasSup is 0, it goes to user if hasUsrIrq is 1, and otherwise to machine.
- R3: From user mode, with hasSup and hasUsrIrq both 1 and the supervisor-level delegation bit for the cause set, the target is user.
- R4: Delegation bit n of a mask belongs to cause code n. The interrupt flag selects the interrupt mask and its absence selects the exception mask. A code of DELEG_W (64) or more is never delegated.
- R5: Entering machine mode sets mppOut to the current privilege, mpieOut to mieIn and mieOut to 0. All other status bits pass through unchanged.
- R6: Entering supervisor mode sets sppOut to bit 0 of the current privilege, spieOut to sieIn and sieOut to 0. All other status bits pass through unchanged.
- R7: Entering user mode sets upieOut to uieIn and uieOut to 0. All other status bits pass through unchanged.
- R8: One cycle after a request, levelWe is one-hot, with bit 0 for user, bit 1 for supervisor and bit 2 for machine. causeOut holds the zero-extended code, with bit XLEN-1 set exactly when the trap is an interrupt. epcOut holds faultPc and tvalOut holds trapVal.
- R9: nextPc is the target level's vector register with bits 1:0 cleared. If those two bits equal 1 and the trap is an interrupt, nextPc is that base plus four times the code.
- R10: privWe, statusWe, pcLoad and resvClear are high for exactly the cycle after each request. In a cycle after no request, they and levelWe are all zero.
- R11: While reset is asserted, the outputs are as follows. tgtPriv is 3. privWe, statusWe and pcLoad are 1. mieOut and mprvOut are 0. nextPc is RESET_VEC. levelWe and resvClear are 0.
- R12: nmiWarn is high in the update of a non-maskable trap taken in machine mode while mieIn is 0, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapReq | input | 1 | One-cycle trap request |
| trapIsIrq | input | 1 | Request is an interrupt |
| trapIsNmi | input | 1 | Request is non-maskable |
| trapCode | input | CODE_W | Cause code |
| trapVal | input | XLEN | Trap value |
| curPriv | input | 2 | Current privilege |
| faultPc | input | XLEN | Address of the trapping instruction |
| hasSup | input | 1 | Supervisor mode implemented |
| hasUsrIrq | input | 1 | User-level traps implemented |
| mDelegExc | input | DELEG_W | Machine exception delegation mask |
| mDelegIrq | input | DELEG_W | Machine interrupt delegation mask |
| sDelegExc | input | DELEG_W | Supervisor exception delegation mask |
| sDelegIrq | input | DELEG_W | Supervisor interrupt delegation mask |
| mTvec | input | XLEN | Machine vector register |
| sTvec | input | XLEN | Supervisor vector register |
| uTvec | input | XLEN | User vector register |
| mieIn | input | 1 | Machine interrupt enable |
| mpieIn | input | 1 | Machine prior enable |
| mppIn | input | 2 | Machine prior privilege |
| sieIn | input | 1 | Supervisor interrupt enable |
| spieIn | input | 1 | Supervisor prior enable |
| sppIn | input | 1 | Supervisor prior privilege |
| uieIn | input | 1 | User interrupt enable |
| upieIn | input | 1 | User prior enable |
| mprvIn | input | 1 | Modify-privilege bit |
| nmiEnIn | input | 1 | Non-maskable enable |
| tgtPriv | output | 2 | New privilege |
| privWe | output | 1 | Privilege write strobe |
| levelWe | output | 3 | One-hot cause/epc/tval write strobe per level |
| causeOut | output | XLEN | Cause value |
| epcOut | output | XLEN | Return address value |
| tvalOut | output | XLEN | Trap value |
| statusWe | output | 1 | Status write strobe |
| mieOut | output | 1 | New machine enable |
| mpieOut | output | 1 | New machine prior enable |
| mppOut | output | 2 | New machine prior privilege |
| sieOut | output | 1 | New supervisor enable |
| spieOut | output | 1 | New supervisor prior enable |
| sppOut | output | 1 | New supervisor prior privilege |
| uieOut | output | 1 | New user enable |
| upieOut | output | 1 | New user prior enable |
| mprvOut | output | 1 | New modify-privilege bit |
| nmiEnWe | output | 1 | Non-maskable enable write strobe |
| nmiEnOut | output | 1 | New non-maskable enable |
| nmiWarn | output | 1 | Non-maskable trap overwrote machine handler state |
| pcLoad | output | 1 | Program counter load strobe |
| nextPc | output | XLEN | Handler or reset address |
| resvClear | output | 1 | Load reservation clear pulse |

## Verification
A routing fault shows up one cycle after the request as the wrong bit in levelWe and the wrong tgtPriv, so the wrong level's registers are overwritten. A wrong vector choice appears in nextPc in that same cycle. A status bit computed from the wrong level, or a stale strobe register, shows up as a bad field or as a strobe that stays high in the cycle that follows. A reference model is compared against every field on every clock, over directed corner cases and a few hundred mixed requests. With that comparison, any such fault is reported in the cycle it first appears.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_H = 2'b10,
    PRIV_M = 2'b11
  } priv_e;

  // strobes passed from routing control to the update datapath
  typedef struct packed {
    logic  fire;
    logic  nmi;
    logic  warn;
    priv_e level;
  } trap_strobe_t;
endpackage

// File: rtl/trap_route_ctrl.sv
module trap_route_ctrl
  import trap_entry_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int DELEG_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapReq,
  input  logic               trapIsIrq,
  input  logic               trapIsNmi,
  input  logic [CODE_W-1:0]  trapCode,
  input  logic [1:0]         curPriv,
  input  logic               hasSup,
  input  logic               hasUsrIrq,
  input  logic [DELEG_W-1:0] mDelegExc,
  input  logic [DELEG_W-1:0] mDelegIrq,
  input  logic [DELEG_W-1:0] sDelegExc,
  input  logic [DELEG_W-1:0] sDelegIrq,
  input  logic               mieIn,
  output trap_strobe_t       strobe
);
  localparam int IDX_W = $clog2(DELEG_W);

  logic             inRange;
  logic [IDX_W-1:0] bitIdx;
  logic             mHit;
  logic             sHit;
  priv_e            lvl;

  assign inRange = 32'(trapCode) < DELEG_W;
  assign bitIdx  = trapCode[IDX_W-1:0];
  assign mHit    = inRange && (trapIsIrq ? mDelegIrq[bitIdx] : mDelegExc[bitIdx]);
  assign sHit    = inRange && (trapIsIrq ? sDelegIrq[bitIdx] : sDelegExc[bitIdx]);

  always_comb begin
    lvl = PRIV_M;
    if (!trapIsNmi) begin
      if (curPriv != PRIV_M && mHit)
        lvl = hasSup ? PRIV_S : (hasUsrIrq ? PRIV_U : PRIV_M);
      if (curPriv == PRIV_U && hasSup && hasUsrIrq && sHit)
        lvl = PRIV_U;
    end
  end

  always_comb begin
    strobe.fire  = trapReq;
    strobe.nmi   = trapReq && trapIsNmi;
    strobe.warn  = trapReq && trapIsNmi && curPriv == PRIV_M && !mieIn;
    strobe.level = lvl;
  end

  // R1: non-maskable traps ignore delegation
  p_nmi_machine_r1: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && trapIsNmi) |-> strobe.level == PRIV_M);
  // R2: machine mode never hands a trap downward
  p_machine_keeps_r2: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && curPriv == PRIV_M) |-> strobe.level == PRIV_M);
  // R2: without lower trap levels everything stays in machine mode
  p_no_lower_r2: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !hasSup && !hasUsrIrq) |-> strobe.level == PRIV_M);
endmodule

// File: rtl/trap_state_dp.sv
module trap_state_dp
  import trap_entry_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter int              CODE_W    = 8,
  parameter logic [XLEN-1:0] RESET_VEC = 'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  trap_strobe_t      strobe,
  input  logic              trapIsIrq,
  input  logic [CODE_W-1:0] trapCode,
  input  logic [XLEN-1:0]   trapVal,
  input  logic [1:0]        curPriv,
  input  logic [XLEN-1:0]   faultPc,
  input  logic [XLEN-1:0]   mTvec,
  input  logic [XLEN-1:0]   sTvec,
  input  logic [XLEN-1:0]   uTvec,
  input  logic              mieIn,
  input  logic              mpieIn,
  input  logic [1:0]        mppIn,
  input  logic              sieIn,
  input  logic              spieIn,
  input  logic              sppIn,
  input  logic              uieIn,
  input  logic              upieIn,
  input  logic              mprvIn,
  input  logic              nmiEnIn,
  output logic [1:0]        tgtPriv,
  output logic              privWe,
  output logic [2:0]        levelWe,
  output logic [XLEN-1:0]   causeOut,
  output logic [XLEN-1:0]   epcOut,
  output logic [XLEN-1:0]   tvalOut,
  output logic              statusWe,
  output logic              mieOut,
  output logic              mpieOut,
  output logic [1:0]        mppOut,
  output logic              sieOut,
  output logic              spieOut,
  output logic              sppOut,
  output logic              uieOut,
  output logic              upieOut,
  output logic              mprvOut,
  output logic              nmiEnWe,
  output logic              nmiEnOut,
  output logic              nmiWarn,
  output logic              pcLoad,
  output logic [XLEN-1:0]   nextPc,
  output logic              resvClear
);
  logic [XLEN-1:0] selTvec;
  logic [XLEN-1:0] vecBase;
  logic [XLEN-1:0] pcNext;
  logic [XLEN-1:0] causeNext;
  logic [2:0]      weNext;
  logic            nMie, nMpie, nSie, nSpie, nSpp, nUie, nUpie;
  logic [1:0]      nMpp;

  always_comb begin
    unique case (strobe.level)
      PRIV_U:  begin selTvec = uTvec; weNext = 3'b001; end
      PRIV_S:  begin selTvec = sTvec; weNext = 3'b010; end
      default: begin selTvec = mTvec; weNext = 3'b100; end
    endcase
  end

  assign vecBase = {selTvec[XLEN-1:2], 2'b00};
  assign pcNext  = (selTvec[1:0] == 2'b01 && trapIsIrq)
                   ? vecBase + XLEN'({trapCode, 2'b00}) : vecBase;

  always_comb begin
    causeNext = XLEN'(trapCode);
    causeNext[XLEN-1] = causeNext[XLEN-1] | trapIsIrq;
  end

  always_comb begin
    nMie = mieIn;  nMpie = mpieIn; nMpp = mppIn;
    nSie = sieIn;  nSpie = spieIn; nSpp = sppIn;
    nUie = uieIn;  nUpie = upieIn;
    unique case (strobe.level)
      PRIV_U:  begin nUpie = uieIn; nUie = 1'b0; end
      PRIV_S:  begin nSpp = curPriv[0]; nSpie = sieIn; nSie = 1'b0; end
      default: begin nMpp = curPriv; nMpie = mieIn; nMie = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtPriv   <= PRIV_M;
      privWe    <= 1'b1;
      levelWe   <= '0;
      causeOut  <= '0;
      epcOut    <= '0;
      tvalOut   <= '0;
      statusWe  <= 1'b1;
      mieOut    <= 1'b0;
      mpieOut   <= 1'b0;
      mppOut    <= 2'b00;
      sieOut    <= 1'b0;
      spieOut   <= 1'b0;
      sppOut    <= 1'b0;
      uieOut    <= 1'b0;
      upieOut   <= 1'b0;
      mprvOut   <= 1'b0;
      nmiEnWe   <= 1'b0;
      nmiEnOut  <= 1'b0;
      nmiWarn   <= 1'b0;
      pcLoad    <= 1'b1;
      nextPc    <= RESET_VEC;
      resvClear <= 1'b0;
    end else begin
      privWe    <= strobe.fire;
      statusWe  <= strobe.fire;
      pcLoad    <= strobe.fire;
      resvClear <= strobe.fire;
      levelWe   <= strobe.fire ? weNext : 3'b000;
      nmiEnWe   <= strobe.nmi;
      nmiWarn   <= strobe.warn;
      if (strobe.fire) begin
        tgtPriv  <= strobe.level;
        causeOut <= causeNext;
        epcOut   <= faultPc;
        tvalOut  <= trapVal;
        nextPc   <= pcNext;
        mieOut   <= nMie;
        mpieOut  <= nMpie;
        mppOut   <= nMpp;
        sieOut   <= nSie;
        spieOut  <= nSpie;
        sppOut   <= nSpp;
        uieOut   <= nUie;
        upieOut  <= nUpie;
        mprvOut  <= mprvIn;
        nmiEnOut <= nmiEnIn && !strobe.nmi;
      end
    end
  end

  // R8: at most one level's registers are written
  p_onehot_we_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(levelWe));
  // R10: every request yields a reservation clear next cycle
  p_resv_after_fire_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> resvClear && pcLoad);
  // R10: a quiet cycle leaves all strobes low
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fire |=> !pcLoad && levelWe == 3'b000 && !statusWe);
  // R5: a machine entry always masks machine interrupts
  p_mie_cleared_r5: assert property (@(posedge clk) disable iff (!rstN)
    levelWe[2] |-> !mieOut);
  // R1: non-maskable entry never re-enables itself
  p_nmi_mask_r1: assert property (@(posedge clk) disable iff (!rstN)
    nmiEnWe |-> !nmiEnOut && tgtPriv == PRIV_M);
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter int              CODE_W    = 8,
  parameter int              DELEG_W   = 64,
  parameter logic [XLEN-1:0] RESET_VEC = 'h1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapReq,
  input  logic               trapIsIrq,
  input  logic               trapIsNmi,
  input  logic [CODE_W-1:0]  trapCode,
  input  logic [XLEN-1:0]    trapVal,
  input  logic [1:0]         curPriv,
  input  logic [XLEN-1:0]    faultPc,
  input  logic               hasSup,
  input  logic               hasUsrIrq,
  input  logic [DELEG_W-1:0] mDelegExc,
  input  logic [DELEG_W-1:0] mDelegIrq,
  input  logic [DELEG_W-1:0] sDelegExc,
  input  logic [DELEG_W-1:0] sDelegIrq,
  input  logic [XLEN-1:0]    mTvec,
  input  logic [XLEN-1:0]    sTvec,
  input  logic [XLEN-1:0]    uTvec,
  input  logic               mieIn,
  input  logic               mpieIn,
  input  logic [1:0]         mppIn,
  input  logic               sieIn,
  input  logic               spieIn,
  input  logic               sppIn,
  input  logic               uieIn,
  input  logic               upieIn,
  input  logic               mprvIn,
  input  logic               nmiEnIn,
  output logic [1:0]         tgtPriv,
  output logic               privWe,
  output logic [2:0]         levelWe,
  output logic [XLEN-1:0]    causeOut,
  output logic [XLEN-1:0]    epcOut,
  output logic [XLEN-1:0]    tvalOut,
  output logic               statusWe,
  output logic               mieOut,
  output logic               mpieOut,
  output logic [1:0]         mppOut,
  output logic               sieOut,
  output logic               spieOut,
  output logic               sppOut,
  output logic               uieOut,
  output logic               upieOut,
  output logic               mprvOut,
  output logic               nmiEnWe,
  output logic               nmiEnOut,
  output logic               nmiWarn,
  output logic               pcLoad,
  output logic [XLEN-1:0]    nextPc,
  output logic               resvClear
);
  trap_strobe_t strobe;

  trap_route_ctrl #(.CODE_W(CODE_W), .DELEG_W(DELEG_W)) uRoute (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapIsIrq(trapIsIrq),
    .trapIsNmi(trapIsNmi), .trapCode(trapCode), .curPriv(curPriv),
    .hasSup(hasSup), .hasUsrIrq(hasUsrIrq), .mDelegExc(mDelegExc),
    .mDelegIrq(mDelegIrq), .sDelegExc(sDelegExc), .sDelegIrq(sDelegIrq),
    .mieIn(mieIn), .strobe(strobe)
  );

  trap_state_dp #(.XLEN(XLEN), .CODE_W(CODE_W), .RESET_VEC(RESET_VEC)) uState (
    .clk(clk), .rstN(rstN), .strobe(strobe), .trapIsIrq(trapIsIrq),
    .trapCode(trapCode), .trapVal(trapVal), .curPriv(curPriv),
    .faultPc(faultPc), .mTvec(mTvec), .sTvec(sTvec), .uTvec(uTvec),
    .mieIn(mieIn), .mpieIn(mpieIn), .mppIn(mppIn), .sieIn(sieIn),
    .spieIn(spieIn), .sppIn(sppIn), .uieIn(uieIn), .upieIn(upieIn),
    .mprvIn(mprvIn), .nmiEnIn(nmiEnIn), .tgtPriv(tgtPriv), .privWe(privWe),
    .levelWe(levelWe), .causeOut(causeOut), .epcOut(epcOut),
    .tvalOut(tvalOut), .statusWe(statusWe), .mieOut(mieOut),
    .mpieOut(mpieOut), .mppOut(mppOut), .sieOut(sieOut),
    .spieOut(spieOut), .sppOut(sppOut), .uieOut(uieOut),
    .upieOut(upieOut), .mprvOut(mprvOut), .nmiEnWe(nmiEnWe),
    .nmiEnOut(nmiEnOut), .nmiWarn(nmiWarn), .pcLoad(pcLoad),
    .nextPc(nextPc), .resvClear(resvClear)
  );
endmodule

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] RVEC = 64'h1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic req, irq, nmi;
  logic [7:0] code;
  logic [63:0] tval, fpc, mde, mdi, sde, sdi, mtv, stv, utv;
  logic [1:0] cur, mppI;
  logic sup, nx, mieI, mpieI, sieI, spieI, sppI, uieI, upieI, mprvI, nmiEnI;

  logic [1:0] tgtPriv, mppOut;
  logic privWe, statusWe, mieOut, mpieOut, sieOut, spieOut, sppOut, uieOut, upieOut;
  logic mprvOut, nmiEnWe, nmiEnOut, nmiWarn, pcLoad, resvClear;
  logic [2:0] levelWe;
  logic [63:0] causeOut, epcOut, tvalOut, nextPc;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_ctrl dut (
    .clk(clk), .rstN(rstN), .trapReq(req), .trapIsIrq(irq), .trapIsNmi(nmi),
    .trapCode(code), .trapVal(tval), .curPriv(cur), .faultPc(fpc),
    .hasSup(sup), .hasUsrIrq(nx), .mDelegExc(mde), .mDelegIrq(mdi),
    .sDelegExc(sde), .sDelegIrq(sdi), .mTvec(mtv), .sTvec(stv), .uTvec(utv),
    .mieIn(mieI), .mpieIn(mpieI), .mppIn(mppI), .sieIn(sieI), .spieIn(spieI),
    .sppIn(sppI), .uieIn(uieI), .upieIn(upieI), .mprvIn(mprvI), .nmiEnIn(nmiEnI),
    .tgtPriv(tgtPriv), .privWe(privWe), .levelWe(levelWe), .causeOut(causeOut),
    .epcOut(epcOut), .tvalOut(tvalOut), .statusWe(statusWe), .mieOut(mieOut),
    .mpieOut(mpieOut), .mppOut(mppOut), .sieOut(sieOut), .spieOut(spieOut),
    .sppOut(sppOut), .uieOut(uieOut), .upieOut(upieOut), .mprvOut(mprvOut),
    .nmiEnWe(nmiEnWe), .nmiEnOut(nmiEnOut), .nmiWarn(nmiWarn), .pcLoad(pcLoad),
    .nextPc(nextPc), .resvClear(resvClear)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    req = 0; irq = 0; nmi = 0; code = 8'd2; tval = 64'hBAD0_0000_0000_0017;
    fpc = 64'h8000_1234; cur = 2'd0; sup = 1; nx = 1;
    mde = '0; mdi = '0; sde = '0; sdi = '0;
    mtv = 64'h8000_0000; stv = 64'h4000_0100; utv = 64'h2000_0200;
    mieI = 1; mpieI = 0; mppI = 2'd1; sieI = 1; spieI = 0; sppI = 1;
    uieI = 1; upieI = 0; mprvI = 1; nmiEnI = 1;
  endtask

  // behavioural reference: computes the expected update and compares one cycle later
  task automatic step(string routeTag);
    int t;
    logic [63:0] md, sd, tv, base, expPc, expCause;
    logic eMie, eMpie, eSie, eSpie, eSpp, eUie, eUpie;
    logic [1:0] eMpp;
    bit fire, isN, wantWarn;
    fire = req; isN = req && nmi;
    wantWarn = isN && cur == 2'd3 && !mieI;
    t = 3;
    md = irq ? mdi : mde;
    sd = irq ? sdi : sde;
    if (!nmi && code < 64) begin
      if (cur != 2'd3 && md[code[5:0]]) t = sup ? 1 : (nx ? 0 : 3);
      if (cur == 2'd0 && sup && nx && sd[code[5:0]]) t = 0;
    end
    tv = (t == 0) ? utv : (t == 1) ? stv : mtv;
    base = tv & ~64'd3;
    expPc = (tv[1:0] == 2'd1 && irq) ? base + 64'(code) * 4 : base;
    expCause = 64'(code) | (irq ? (64'd1 << 63) : 64'd0);
    eMie = mieI; eMpie = mpieI; eMpp = mppI; eSie = sieI; eSpie = spieI;
    eSpp = sppI; eUie = uieI; eUpie = upieI;
    if (t == 3) begin eMpp = cur; eMpie = mieI; eMie = 0; end
    else if (t == 1) begin eSpp = cur[0]; eSpie = sieI; eSie = 0; end
    else begin eUpie = uieI; eUie = 0; end
    begin
      logic eNmiEn = nmiEnI && !isN;
      @(negedge clk);
      if (fire) begin
        chk(routeTag, 64'(tgtPriv), 64'(t));
        chk("R8 level write", 64'(levelWe), (t == 0) ? 64'd1 : (t == 1) ? 64'd2 : 64'd4);
        chk("R8 cause", causeOut, expCause);
        chk("R8 epc", epcOut, fpc);
        chk("R8 tval", tvalOut, tval);
        chk("R5 mie", 64'(mieOut), 64'(eMie));
        chk("R5 mpie", 64'(mpieOut), 64'(eMpie));
        chk("R5 mpp", 64'(mppOut), 64'(eMpp));
        chk("R6 sie", 64'(sieOut), 64'(eSie));
        chk("R6 spie", 64'(spieOut), 64'(eSpie));
        chk("R6 spp", 64'(sppOut), 64'(eSpp));
        chk("R7 uie", 64'(uieOut), 64'(eUie));
        chk("R7 upie", 64'(upieOut), 64'(eUpie));
        chk("R5 mprv kept", 64'(mprvOut), 64'(mprvI));
        chk("R9 next pc", nextPc, expPc);
        chk("R10 strobes", {privWe, statusWe, pcLoad, resvClear}, 64'hF);
        chk("R1 nmi enable write", 64'(nmiEnWe), 64'(isN));
        chk("R1 nmi enable value", 64'(nmiEnOut), 64'(eNmiEn));
        chk("R12 warn", 64'(nmiWarn), 64'(wantWarn));
      end else begin
        chk("R10 idle strobes", {privWe, statusWe, pcLoad, resvClear, nmiEnWe, nmiWarn}, 64'h0);
        chk("R10 idle level write", 64'(levelWe), 64'h0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    defaults();
    @(negedge clk); @(negedge clk);
    // R11: reset update
    chk("R11 priv", 64'(tgtPriv), 64'd3);
    chk("R11 strobes", {privWe, statusWe, pcLoad}, 64'h7);
    chk("R11 mie mprv", {mieOut, mprvOut}, 64'h0);
    chk("R11 pc", nextPc, RVEC);
    chk("R11 quiet", {levelWe, resvClear}, 64'h0);
    rstN = 1'b1;
    step("R10 first idle");

    // R2: machine mode keeps its traps even with full delegation
    defaults(); req = 1; cur = 2'd3; mde = '1; sde = '1; step("R2 machine keeps");
    // R2: supervisor target from supervisor
    defaults(); req = 1; cur = 2'd1; mde = 64'd1 << 2; step("R2 to supervisor");
    // R2: no supervisor, user traps present
    defaults(); req = 1; cur = 2'd0; sup = 0; mde = 64'd1 << 2; step("R2 to user");
    // R2: neither present
    defaults(); req = 1; cur = 2'd0; sup = 0; nx = 0; mde = '1; step("R2 stays machine");
    // R3: second-level delegation to user
    defaults(); req = 1; cur = 2'd0; mde = 64'd1 << 2; sde = 64'd1 << 2; step("R3 to user");
    // R3: second level alone is enough from user mode
    defaults(); req = 1; cur = 2'd0; sde = 64'd1 << 2; step("R3 second level only");
    // R4: interrupt uses interrupt mask
    defaults(); req = 1; irq = 1; code = 8'd5; cur = 2'd1; mdi = 64'd1 << 5; step("R4 irq mask");
    defaults(); req = 1; irq = 1; code = 8'd5; cur = 2'd1; mde = 64'd1 << 5; step("R4 exc mask ignored");
    // R4: codes at or above 64 never delegated
    defaults(); req = 1; code = 8'd70; cur = 2'd1; mde = '1; mdi = '1; step("R4 high code");
    // R1: non-maskable with full delegation from supervisor
    defaults(); req = 1; irq = 1; nmi = 1; cur = 2'd1; mdi = '1; mde = '1; step("R1 nmi machine");
    // R12: non-maskable in machine mode with interrupts off
    defaults(); req = 1; irq = 1; nmi = 1; cur = 2'd3; mieI = 0; step("R12 warn case");
    // R9: vectored interrupt, vectored exception, reserved mode
    defaults(); req = 1; irq = 1; code = 8'd7; cur = 2'd3; mtv = 64'h8000_0001; step("R9 vectored irq");
    defaults(); req = 1; code = 8'd7; cur = 2'd3; mtv = 64'h8000_0001; step("R9 vectored exc");
    defaults(); req = 1; irq = 1; code = 8'd7; cur = 2'd3; mtv = 64'h8000_0002; step("R9 reserved mode");
    defaults(); req = 1; irq = 1; code = 8'd3; cur = 2'd1; mdi = 64'd1 << 3; stv = 64'h4000_0101; step("R9 supervisor vectored");
    // R10: back-to-back then idle
    defaults(); req = 1; step("R10 back to back a");
    req = 1; cur = 2'd1; step("R10 back to back b");
    req = 0; step("R10 idle");

    for (int i = 0; i < 400; i++) begin
      req = ($urandom % 4) != 0;
      irq = $urandom % 2; nmi = ($urandom % 8) == 0;
      code = 8'($urandom % 80);
      case ($urandom % 3) 0: cur = 2'd0; 1: cur = 2'd1; default: cur = 2'd3; endcase
      sup = $urandom % 2; nx = $urandom % 2;
      mde = {$urandom, $urandom}; mdi = {$urandom, $urandom};
      sde = {$urandom, $urandom}; sdi = {$urandom, $urandom};
      mtv = {$urandom, $urandom}; stv = {$urandom, $urandom}; utv = {$urandom, $urandom};
      tval = {$urandom, $urandom}; fpc = {$urandom, $urandom};
      {mieI, mpieI, sieI, spieI, sppI, uieI, upieI, mprvI} = 8'($urandom);
      mppI = 2'($urandom); nmiEnI = $urandom % 2;
      step("R4 mixed route");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule